// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status register of a serial NOR flash and decides whether each write-type command may run. The SPI front end decodes the command opcode and raises a single-cycle strobe for it. With the strobe it gives the target address, the status data byte for a status write, and a flag that says whether the clock count of the transaction was a whole number of bytes. For every strobe the block answers one cycle later with an accept or a reject pulse. An accepted program, erase or status write also raises a start pulse for the internal cycle. The block then stays busy until the array sequencer returns a done strobe.

Protection works at three levels. A command that modifies data needs the write-enable latch to have been set by an earlier enable command. A two-bit protect level fences off the top quarter, the top half or all of the array against program and erase. A lock bit, together with a low level on the write-protect pin, freezes the lock bit and the protect level. The non-volatile bits come out of reset with parameter values, which stand for the stored image. The busy flag and the write-enable latch always reset to zero.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte is laid out as bit0 busy, bit1 write-enable latch, bit2 protect level low bit, bit3 protect level high bit, bit7 lock. Bits 4 to 6 read zero. After reset, busy and the latch are 0 and the protect level and lock take their parameter values (default 0).
- R2: While not busy, an enable strobe is accepted and sets the latch, and a disable strobe is accepted and clears the latch. Neither strobe looks at the clock-count flag.
- R3: A status write, program, sector erase or chip erase strobe seen while the latch is 0 is rejected, starts no cycle and changes no status bit.
- R4: A modifying strobe that arrives with the clock-count flag low is rejected.
- R5: An accepted modifying command pulses startCycle together with cmdAccept, and the status byte shows busy from that cycle on. A rejected command leaves the latch unchanged.
- R6: A done strobe while busy clears both busy and the latch. A done strobe while idle changes nothing.
- R7: While busy, every command strobe, enable and disable included, is rejected and leaves the status byte unchanged.
- R8: Program and sector erase are rejected when the address is inside the protected region. Level 0 protects nothing. Level 1 protects addresses whose top two bits are 11. Level 2 protects addresses whose top bit is 1. Level 3 protects every address.
- R9: A chip erase is rejected whenever the protect level is nonzero.
- R10: An accepted status write loads the protect level from data bits 3:2 and the lock from data bit 7. The other data bits are ignored.
- R11: With lock = 1 and wpN = 0, a status write is rejected. With wpN = 1 the same write is accepted.
- R12: At most one command strobe is raised per cycle. Each strobe produces exactly one of cmdAccept or cmdReject, one cycle later, and neither pulse appears without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| cmdWrEnable | input | 1 | Write-enable command strobe |
| cmdWrDisable | input | 1 | Write-disable command strobe |
| cmdStatusWr | input | 1 | Status-write command strobe |
| cmdProgram | input | 1 | Page-program command strobe |
| cmdSectorErase | input | 1 | Sector-erase command strobe |
| cmdChipErase | input | 1 | Whole-array erase command strobe |
| cmdAddr | input | ADDR_W | Byte address of program or sector erase |
| wrsrData | input | 8 | New status value for a status write |
| wpN | input | 1 | Write-protect pin, active low |
| clkCountOk | input | 1 | Transaction clock count was a multiple of eight |
| cycleDone | input | 1 | Internal cycle finished |
| statusByte | output | 8 | Status register as read by the host |
| cmdAccept | output | 1 | Command accepted (one-cycle pulse) |
| cmdReject | output | 1 | Command refused (one-cycle pulse) |
| startCycle | output | 1 | Launch the internal program/erase/status cycle |

## Verification
A latch that is set by mistake lets an unauthorised program or erase through: cmdAccept and startCycle appear one cycle after the strobe, where a reject was due. A busy flag stuck at 1 makes every later command reject, and one stuck at 0 makes a second command accept while the first is still running. Both show on the next strobe. A wrong protect level or lock is visible at once in statusByte, and it also flips the verdict on addresses that lie near the quarter and half boundaries.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // Strobes from the decision logic to the register datapath
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic setBusy;
    logic clrBusy;
    logic loadStatus;
  } fsg_strobe_t;

  localparam int STATUS_W = 8;
  localparam int LVL_W    = 2;
endpackage

// File: rtl/fsg_regs.sv
module fsg_regs
  import fsg_pkg::*;
#(
  parameter logic [LVL_W-1:0] RESET_LVL  = '0,
  parameter logic             RESET_LOCK = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  fsg_strobe_t         strb,
  input  logic [STATUS_W-1:0] wrsrData,
  output logic                busy,
  output logic                wrLatch,
  output logic [LVL_W-1:0]    protLvl,
  output logic                regLock,
  output logic [STATUS_W-1:0] statusByte
);
  logic unusedDataBits;
  assign unusedDataBits = ^{wrsrData[6:4], wrsrData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      wrLatch <= 1'b0;
      protLvl <= RESET_LVL;
      regLock <= RESET_LOCK;
    end else begin
      if (strb.setBusy)    busy <= 1'b1;
      else if (strb.clrBusy) busy <= 1'b0;
      if (strb.setLatch)   wrLatch <= 1'b1;
      else if (strb.clrLatch) wrLatch <= 1'b0;
      if (strb.loadStatus) begin
        protLvl <= wrsrData[3:2];
        regLock <= wrsrData[7];
      end
    end
  end

  assign statusByte = {regLock, 3'b000, protLvl, wrLatch, busy};

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.clrBusy) |=> busy) else $error("busy dropped early"); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && strb.clrBusy) |=> (!busy && !wrLatch)) else $error("done did not clear"); // R6

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.clrBusy) |=> ($stable(protLvl) && $stable(regLock))) else $error("status moved while busy"); // R7
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEnable,
  input  logic              cmdWrDisable,
  input  logic              cmdStatusWr,
  input  logic              cmdProgram,
  input  logic              cmdSectorErase,
  input  logic              cmdChipErase,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wpN,
  input  logic              clkCountOk,
  input  logic              cycleDone,
  input  logic              busy,
  input  logic              wrLatch,
  input  logic [LVL_W-1:0]  protLvl,
  input  logic              regLock,
  output fsg_strobe_t       strb,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              startCycle
);
  logic [1:0] addrTop;
  logic       inFence;
  logic       isModify;
  logic       anyCmd;
  logic       modifyOk;
  logic       accept;
  logic       unusedAddr;

  assign addrTop    = cmdAddr[ADDR_W-1 -: 2];
  assign unusedAddr = ^cmdAddr[ADDR_W-3:0];
  assign isModify   = cmdStatusWr | cmdProgram | cmdSectorErase | cmdChipErase;
  assign anyCmd     = isModify | cmdWrEnable | cmdWrDisable;

  always_comb begin
    unique case (protLvl)
      2'd0:    inFence = 1'b0;
      2'd1:    inFence = (addrTop == 2'b11);
      2'd2:    inFence = addrTop[1];
      default: inFence = 1'b1;
    endcase
  end

  always_comb begin
    modifyOk = 1'b0;
    if (cmdStatusWr)                     modifyOk = !(regLock && !wpN);
    else if (cmdProgram || cmdSectorErase) modifyOk = !inFence;
    else if (cmdChipErase)               modifyOk = (protLvl == '0);
  end

  always_comb begin
    if (busy)                             accept = 1'b0;
    else if (cmdWrEnable || cmdWrDisable) accept = 1'b1;
    else if (isModify)                    accept = wrLatch && clkCountOk && modifyOk;
    else                                  accept = 1'b0;
  end

  always_comb begin
    strb.setLatch   = accept && cmdWrEnable;
    strb.clrLatch   = (accept && cmdWrDisable) || (busy && cycleDone);
    strb.setBusy    = accept && isModify;
    strb.clrBusy    = busy && cycleDone;
    strb.loadStatus = accept && cmdStatusWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept  <= 1'b0;
      cmdReject  <= 1'b0;
      startCycle <= 1'b0;
    end else begin
      cmdAccept  <= anyCmd && accept;
      cmdReject  <= anyCmd && !accept;
      startCycle <= accept && isModify;
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdWrEnable, cmdWrDisable, cmdStatusWr, cmdProgram, cmdSectorErase, cmdChipErase}))
    else $error("several command strobes"); // R12

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |=> (cmdAccept ^ cmdReject)) else $error("no single answer"); // R12

  AST_NO_LATCH_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (isModify && !wrLatch) |=> !startCycle) else $error("start without latch"); // R3

  AST_LOCKED_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStatusWr && regLock && !wpN) |=> !cmdAccept) else $error("locked status written"); // R11

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startCycle |-> busy) else $error("start while idle"); // R5
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [1:0]       RESET_LVL  = 2'b00,
  parameter logic             RESET_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEnable,
  input  logic              cmdWrDisable,
  input  logic              cmdStatusWr,
  input  logic              cmdProgram,
  input  logic              cmdSectorErase,
  input  logic              cmdChipErase,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        wrsrData,
  input  logic              wpN,
  input  logic              clkCountOk,
  input  logic              cycleDone,
  output logic [7:0]        statusByte,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              startCycle
);
  fsg_strobe_t      strb;
  logic             busy;
  logic             wrLatch;
  logic [LVL_W-1:0] protLvl;
  logic             regLock;

  fsg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEnable(cmdWrEnable), .cmdWrDisable(cmdWrDisable),
    .cmdStatusWr(cmdStatusWr), .cmdProgram(cmdProgram),
    .cmdSectorErase(cmdSectorErase), .cmdChipErase(cmdChipErase),
    .cmdAddr(cmdAddr), .wpN(wpN), .clkCountOk(clkCountOk), .cycleDone(cycleDone),
    .busy(busy), .wrLatch(wrLatch), .protLvl(protLvl), .regLock(regLock),
    .strb(strb), .cmdAccept(cmdAccept), .cmdReject(cmdReject), .startCycle(startCycle)
  );

  fsg_regs #(.RESET_LVL(RESET_LVL), .RESET_LOCK(RESET_LOCK)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrsrData(wrsrData),
    .busy(busy), .wrLatch(wrLatch), .protLvl(protLvl), .regLock(regLock),
    .statusByte(statusByte)
  );
endmodule

// File: tb/flash_status_guard_bench.sv
module flash_status_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  localparam int K_NONE = 0, K_EN = 1, K_DIS = 2, K_SWR = 3, K_PROG = 4, K_SE = 5, K_CE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEnable = 0, cmdWrDisable = 0, cmdStatusWr = 0;
  logic cmdProgram = 0, cmdSectorErase = 0, cmdChipErase = 0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0] wrsrData = '0;
  logic wpN = 1'b1, clkCountOk = 1'b1, cycleDone = 1'b0;
  logic [7:0] statusByte;
  logic cmdAccept, cmdReject, startCycle;

  int nChecks = 0;
  int nErrors = 0;

  // bench model
  bit mBusy = 0, mLatch = 0, mLock = 0;
  bit [1:0] mLvl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_guard #(.ADDR_W(ADDR_W)) u_flash_status_guard (
    .clk(clk), .rstN(rstN),
    .cmdWrEnable(cmdWrEnable), .cmdWrDisable(cmdWrDisable), .cmdStatusWr(cmdStatusWr),
    .cmdProgram(cmdProgram), .cmdSectorErase(cmdSectorErase), .cmdChipErase(cmdChipErase),
    .cmdAddr(cmdAddr), .wrsrData(wrsrData), .wpN(wpN), .clkCountOk(clkCountOk),
    .cycleDone(cycleDone), .statusByte(statusByte), .cmdAccept(cmdAccept),
    .cmdReject(cmdReject), .startCycle(startCycle)
  );

  function automatic bit fenced(bit [ADDR_W-1:0] a, bit [1:0] lvl);
    case (lvl)
      2'd0: return 1'b0;
      2'd1: return a[ADDR_W-1:ADDR_W-2] == 2'b11;
      2'd2: return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit expAccept(int kind, bit [ADDR_W-1:0] a, bit ok, bit wp);
    if (kind == K_NONE || mBusy) return 1'b0;
    if (kind == K_EN || kind == K_DIS) return 1'b1;
    if (!mLatch || !ok) return 1'b0;
    case (kind)
      K_SWR:        return !(mLock && !wp);
      K_PROG, K_SE: return !fenced(a, mLvl);
      default:      return mLvl == 2'b00;
    endcase
  endfunction

  function automatic bit [7:0] expStatus();
    return {mLock, 3'b000, mLvl, mLatch, mBusy};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doCmd(int kind, bit [ADDR_W-1:0] a, bit [7:0] d, bit ok, bit wp, bit done, string tag);
    bit acc, st, wasBusy;
    acc = expAccept(kind, a, ok, wp);
    st = acc && (kind >= K_SWR);
    wasBusy = mBusy;
    if (acc) begin
      if (kind == K_EN) mLatch = 1;
      else if (kind == K_DIS) mLatch = 0;
      else mBusy = 1;
      if (kind == K_SWR) begin mLvl = d[3:2]; mLock = d[7]; end
    end
    if (wasBusy && done) begin mBusy = 0; mLatch = 0; end
    cmdWrEnable = (kind == K_EN); cmdWrDisable = (kind == K_DIS);
    cmdStatusWr = (kind == K_SWR); cmdProgram = (kind == K_PROG);
    cmdSectorErase = (kind == K_SE); cmdChipErase = (kind == K_CE);
    cmdAddr = a; wrsrData = d; clkCountOk = ok; wpN = wp; cycleDone = done;
    @(negedge clk);
    check(cmdAccept == (kind != K_NONE && acc), tag, "accept", cmdAccept, kind != K_NONE && acc);
    check(cmdReject == (kind != K_NONE && !acc), tag, "reject", cmdReject, kind != K_NONE && !acc);
    check(startCycle == st, tag, "start", startCycle, st);
    check(statusByte == expStatus(), tag, "status", statusByte, expStatus());
    cmdWrEnable = 0; cmdWrDisable = 0; cmdStatusWr = 0;
    cmdProgram = 0; cmdSectorErase = 0; cmdChipErase = 0; cycleDone = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(statusByte == 8'h00, "R1", "reset status", statusByte, 8'h00);
    check(!cmdAccept && !cmdReject && !startCycle, "R1", "reset pulses", {cmdAccept, cmdReject, startCycle}, 0);

    doCmd(K_PROG, 16'h0010, 8'h00, 1, 1, 0, "R3");       // latch clear -> reject
    doCmd(K_NONE, 16'h0, 8'h00, 1, 1, 0, "R12");         // no strobe, no answer
    doCmd(K_EN, 16'h0, 8'h00, 0, 1, 0, "R2");            // enable ignores count flag
    doCmd(K_SWR, 16'h0, 8'h8C, 0, 1, 0, "R4");           // bad count -> reject, latch kept (R5)
    doCmd(K_SWR, 16'h0, 8'hFC, 1, 1, 0, "R10");          // loads lock=1, lvl=3; other bits ignored
    doCmd(K_EN, 16'h0, 8'h00, 1, 1, 0, "R7");            // busy -> reject
    doCmd(K_DIS, 16'h0, 8'h00, 1, 1, 0, "R7");
    doCmd(K_NONE, 16'h0, 8'h00, 1, 1, 1, "R6");          // done clears busy and latch
    doCmd(K_NONE, 16'h0, 8'h00, 1, 1, 1, "R6");          // idle done no effect
    doCmd(K_EN, 16'h0, 8'h00, 1, 0, 0, "R2");
    doCmd(K_SWR, 16'h0, 8'h00, 1, 0, 0, "R11");          // locked + pin low
    doCmd(K_SWR, 16'h0, 8'h04, 1, 1, 0, "R11");          // pin high -> accepted, lvl=1
    doCmd(K_NONE, 16'h0, 8'h00, 1, 1, 1, "R6");
    doCmd(K_EN, 16'h0, 8'h00, 1, 1, 0, "R2");
    doCmd(K_PROG, 16'hC000, 8'h00, 1, 1, 0, "R8");       // top quarter fenced
    doCmd(K_CE, 16'h0, 8'h00, 1, 1, 0, "R9");            // level nonzero
    doCmd(K_SE, 16'hBFFF, 8'h00, 1, 1, 0, "R8");         // just below the fence
    doCmd(K_NONE, 16'h0, 8'h00, 1, 1, 1, "R6");
    doCmd(K_EN, 16'h0, 8'h00, 1, 1, 0, "R2");
    doCmd(K_DIS, 16'h0, 8'h00, 1, 1, 0, "R2");

    for (int i = 0; i < 600; i++) begin
      int kind;
      bit [ADDR_W-1:0] a;
      bit [7:0] d;
      bit ok, wp, done;
      string tag;
      kind = $urandom_range(0, 6);
      if ($urandom_range(0, 3) == 0) kind = K_EN;
      a = ADDR_W'($urandom);
      d = 8'($urandom);
      ok = ($urandom_range(0, 9) != 0);
      wp = $urandom_range(0, 1);
      done = ($urandom_range(0, 3) == 0);
      case (kind)
        K_EN, K_DIS:  tag = "R2";
        K_SWR:        tag = "R10";
        K_PROG, K_SE: tag = "R8";
        K_CE:         tag = "R9";
        default:      tag = "R6";
      endcase
      doCmd(kind, a, d, ok, wp, done, tag);
    end

    summary();
    $finish;
  end
endmodule